// File: doc/BRIEF.md
# Return Address Stack with Checkpoint Repair

This block predicts return targets for an in-order pipeline whose branches may have a delay slot. A call pushes the address where execution resumes after the call. With delay slots, that address is past both the call and its delay slot. A return pops the top entry and uses it as the predicted target. A return that meets an empty stack is predicted not taken, and the fall-through address is offered instead.

Each prediction comes with a checkpoint: a flag that says the stack was used, the top index, and the entry at that index. When the pipeline later squashes a wrong return, it sends the saved index and entry back through the restore command. The entry is written back and becomes the top again. A wrong call is undone with an undo-push command, which drops the speculatively pushed entry. The storage is a circular buffer, so a push onto a full stack overwrites the oldest entry and never stalls.

Top module: `ras_repair`

## Requirements
- R1: After reset the stack is empty, `empty_o` is 1, `pred_valid_o` and `ckpt_used_o` are 0 and `ckpt_idx_o` is 0.
- R2: With `DELAY_SLOT=1` (default) a call pushes `pc_i + 2*INSN_BYTES`, and the new top entry shows on `ckpt_tgt_o` from the cycle after the push.
- R3: A return on a non-empty stack sets `pred_valid_o` and `ckpt_used_o` in the same cycle and drives `pred_tgt_o` with the top entry. The stack drops by one at the next edge.
- R4: A return on an empty stack gives `pred_valid_o=0`, drives `pred_tgt_o` with the fall-through address (the same sum as R2) and leaves the stack unchanged.
- R5: In every cycle `ckpt_idx_o` is the current top index and `ckpt_tgt_o` is the entry at that index, so a return's checkpoint is the index and entry it popped.
- R6: `restore_i` writes `restore_tgt_i` at `restore_idx_i`, makes that index the top and raises the depth by one, saturating at `DEPTH`.
- R7: `undo_push_i` moves the top back by one entry and lowers the depth by one.
- R8: A push onto a full stack overwrites the oldest entry. The depth stays at `DEPTH`, and later returns give the newest `DEPTH` addresses in reverse order.
- R9: The commands take effect in this order of priority: restore, then undo-push, then return, then call. Only one of them acts in a cycle, so a restore in the same cycle as a call wins.
- R10: While `pop_i` is high, `push_i` is ignored, even when the return finds the stack empty.
- R11: `undo_push_i` on an empty stack changes nothing.
- R12: While `undo_push_i` is high, a return or call in the same cycle has no effect and gives no prediction.
- R13: With `DELAY_SLOT=0` a call pushes `pc_i + INSN_BYTES`, and the fall-through address is the same sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| push_i | input | 1 | Call predicted this cycle |
| pop_i | input | 1 | Return predicted this cycle |
| pc_i | input | AW | PC of the branch being predicted |
| restore_i | input | 1 | Undo a mispredicted return using a checkpoint |
| restore_idx_i | input | $clog2(DEPTH) | Checkpointed top index |
| restore_tgt_i | input | AW | Checkpointed entry value |
| undo_push_i | input | 1 | Undo a mispredicted call |
| pred_valid_o | output | 1 | Return predicted taken using the stack |
| pred_tgt_o | output | AW | Predicted target, or the fall-through address |
| empty_o | output | 1 | Stack holds no entries |
| ckpt_used_o | output | 1 | Checkpoint: stack used by this prediction |
| ckpt_idx_o | output | $clog2(DEPTH) | Checkpoint: top index |
| ckpt_tgt_o | output | AW | Checkpoint: entry at the top index |

## Verification
The prediction and checkpoint outputs depend on the current state and inputs only, so they are due in the same cycle as the return. A push, pop, restore or undo takes effect at the next rising edge and is visible from the cycle after it. The bench drives inputs just after the falling edge and compares every output 1 ns later, before the rising edge. A behavioural model advances its state just after each rising edge. Two instances, one with delay slots and one without, receive the same stimulus and are compared with their own expected values in every cycle.

// File: rtl/ras_pkg.sv
package ras_pkg;
  typedef enum logic [2:0] {
    RAS_IDLE,
    RAS_PUSH,
    RAS_POP,
    RAS_UNDO,
    RAS_RESTORE
  } ras_op_e;
endpackage

// File: rtl/ras_ret_addr.sv
module ras_ret_addr #(
  parameter int AW         = 32,
  parameter int INSN_BYTES = 4,
  parameter bit DELAY_SLOT = 1'b1
) (
  input  logic [AW-1:0] pc_i,
  output logic [AW-1:0] ret_o
);
  generate
    if (DELAY_SLOT) begin : g_skip_slot
      assign ret_o = pc_i + AW'(2 * INSN_BYTES);
    end else begin : g_next
      assign ret_o = pc_i + AW'(INSN_BYTES);
    end
  endgenerate
endmodule

// File: rtl/ras_ptr.sv
module ras_ptr
  import ras_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  ras_op_e       op_i,
  input  logic [IW-1:0] restore_idx_i,
  output logic [IW-1:0] top_o,
  output logic [IW-1:0] top_inc_o,
  output logic          empty_o
);
  logic [CW-1:0] cnt_q;
  logic [IW-1:0] top_dec;
  logic          full;

  assign top_inc_o = (top_o == IW'(DEPTH - 1)) ? '0 : top_o + 1'b1;
  assign top_dec   = (top_o == '0) ? IW'(DEPTH - 1) : top_o - 1'b1;
  assign full      = (cnt_q == CW'(DEPTH));
  assign empty_o   = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      top_o <= '0;
      cnt_q <= '0;
    end else begin
      unique case (op_i)
        RAS_PUSH: begin
          top_o <= top_inc_o;
          if (!full) cnt_q <= cnt_q + 1'b1;
        end
        RAS_POP, RAS_UNDO: begin
          if (!empty_o) begin
            top_o <= top_dec;
            cnt_q <= cnt_q - 1'b1;
          end
        end
        RAS_RESTORE: begin
          top_o <= restore_idx_i;
          if (!full) cnt_q <= cnt_q + 1'b1;
        end
        default: ;
      endcase
    end
  end

  p_push_wrap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == RAS_PUSH |=> top_o == (($past(top_o) == IW'(DEPTH - 1)) ? '0 : $past(top_o) + 1'b1));
  p_full_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == RAS_PUSH && full) |=> full);
  p_restore_top_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == RAS_RESTORE |=> top_o == $past(restore_idx_i));
  p_undo_empty_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == RAS_UNDO && empty_o) |=> (empty_o && $stable(top_o)));
  p_undo_depth_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == RAS_UNDO && !empty_o) |=> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/ras_store.sv
module ras_store #(
  parameter int DEPTH = 16,
  parameter int AW    = 32,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [IW-1:0] waddr_i,
  input  logic [AW-1:0] wdata_i,
  input  logic [IW-1:0] raddr_i,
  output logic [AW-1:0] rdata_o
);
  logic [AW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];

  p_write_lands_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mem_q[$past(waddr_i)] == $past(wdata_i));
endmodule

// File: rtl/ras_repair.sv
module ras_repair
  import ras_pkg::*;
#(
  parameter int DEPTH      = 16,
  parameter int AW         = 32,
  parameter int INSN_BYTES = 4,
  parameter bit DELAY_SLOT = 1'b1,
  localparam int IW        = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [AW-1:0] pc_i,
  input  logic          restore_i,
  input  logic [IW-1:0] restore_idx_i,
  input  logic [AW-1:0] restore_tgt_i,
  input  logic          undo_push_i,
  output logic          pred_valid_o,
  output logic [AW-1:0] pred_tgt_o,
  output logic          empty_o,
  output logic          ckpt_used_o,
  output logic [IW-1:0] ckpt_idx_o,
  output logic [AW-1:0] ckpt_tgt_o
);
  ras_op_e       op;
  logic [IW-1:0] top, top_inc, waddr;
  logic [AW-1:0] ret_addr, rdata, wdata;
  logic          we;

  // restore > undo-push > return > call
  always_comb begin
    if (restore_i)        op = RAS_RESTORE;
    else if (undo_push_i) op = RAS_UNDO;
    else if (pop_i)       op = empty_o ? RAS_IDLE : RAS_POP;
    else if (push_i)      op = RAS_PUSH;
    else                  op = RAS_IDLE;
  end

  assign we    = (op == RAS_PUSH) || (op == RAS_RESTORE);
  assign waddr = (op == RAS_RESTORE) ? restore_idx_i : top_inc;
  assign wdata = (op == RAS_RESTORE) ? restore_tgt_i : ret_addr;

  ras_ret_addr #(.AW(AW), .INSN_BYTES(INSN_BYTES), .DELAY_SLOT(DELAY_SLOT)) u_ret (
    .pc_i  (pc_i),
    .ret_o (ret_addr)
  );

  ras_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .op_i          (op),
    .restore_idx_i (restore_idx_i),
    .top_o         (top),
    .top_inc_o     (top_inc),
    .empty_o       (empty_o)
  );

  ras_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we),
    .waddr_i (waddr),
    .wdata_i (wdata),
    .raddr_i (top),
    .rdata_o (rdata)
  );

  assign pred_valid_o = (op == RAS_POP);
  assign ckpt_used_o  = (op == RAS_POP);
  assign pred_tgt_o   = pred_valid_o ? rdata : ret_addr;
  assign ckpt_idx_o   = top;
  assign ckpt_tgt_o   = rdata;

  p_push_tgt_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i && !restore_i && !undo_push_i) |=> ckpt_tgt_o == $past(ret_addr));
  p_empty_pop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty_o && !restore_i && !undo_push_i && !push_i) |=> empty_o);
  p_restore_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_i |=> (ckpt_idx_o == $past(restore_idx_i) && ckpt_tgt_o == $past(restore_tgt_i)));
  p_undo_no_pred_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (undo_push_i || restore_i) |-> !pred_valid_o);
endmodule

// File: tb/ras_repair_tb.sv
module ras_repair_tb_top;
  localparam int DEPTH = 16;
  localparam int AW    = 32;
  localparam int IW    = $clog2(DEPTH);
  localparam int INSN  = 4;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          push_i = 1'b0, pop_i = 1'b0, restore_i = 1'b0, undo_push_i = 1'b0;
  logic [AW-1:0] pc_i = '0, restore_tgt_i = '0;
  logic [IW-1:0] restore_idx_i = '0;

  logic          v0, e0, u0, v1, e1, u1;
  logic [AW-1:0] p0, t0, p1, t1;
  logic [IW-1:0] i0, i1;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  logic [AW-1:0] m_mem [2][DEPTH];
  int            m_top, m_cnt;

  always #2 clk = ~clk;

  ras_repair #(.DEPTH(DEPTH), .AW(AW), .INSN_BYTES(INSN), .DELAY_SLOT(1'b1)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .push_i(push_i), .pop_i(pop_i), .pc_i(pc_i),
    .restore_i(restore_i), .restore_idx_i(restore_idx_i), .restore_tgt_i(restore_tgt_i),
    .undo_push_i(undo_push_i), .pred_valid_o(v0), .pred_tgt_o(p0), .empty_o(e0),
    .ckpt_used_o(u0), .ckpt_idx_o(i0), .ckpt_tgt_o(t0));

  ras_repair #(.DEPTH(DEPTH), .AW(AW), .INSN_BYTES(INSN), .DELAY_SLOT(1'b0)) dut_nd_i (
    .clk_i(clk), .rst_ni(rst_ni), .push_i(push_i), .pop_i(pop_i), .pc_i(pc_i),
    .restore_i(restore_i), .restore_idx_i(restore_idx_i), .restore_tgt_i(restore_tgt_i),
    .undo_push_i(undo_push_i), .pred_valid_o(v1), .pred_tgt_o(p1), .empty_o(e1),
    .ckpt_used_o(u1), .ckpt_idx_o(i1), .ckpt_tgt_o(t1));

  function automatic logic [AW-1:0] step_of(int k);
    return (k == 0) ? AW'(2 * INSN) : AW'(INSN);
  endfunction

  task automatic compare(string tag);
    for (int k = 0; k < 2; k++) begin
      logic          ev;
      logic [AW-1:0] ep;
      logic [AW+AW+IW+2:0] act, exp;
      string         t;
      ev  = pop_i && !restore_i && !undo_push_i && (m_cnt != 0);
      ep  = ev ? m_mem[k][m_top] : pc_i + step_of(k);
      exp = {(m_cnt == 0), ev, ev, IW'(m_top), ep, m_mem[k][m_top]};
      if (k == 0) act = {e0, v0, u0, i0, p0, t0};
      else        act = {e1, v1, u1, i1, p1, t1};
      t = (k == 0) ? tag : {tag, "/R13"};
      checks++;
      if (act !== exp) begin
        failures++;
        $display("FAIL %s: {empty,valid,used,idx,pred,ckpt} actual=%h expected=%h", t, act, exp);
      end
    end
  endtask

  task automatic model_update();
    if (restore_i) begin
      m_top = int'(restore_idx_i);
      for (int k = 0; k < 2; k++) m_mem[k][m_top] = restore_tgt_i;
      if (m_cnt < DEPTH) m_cnt++;
    end else if (undo_push_i || pop_i) begin
      if (m_cnt > 0) begin
        m_top = (m_top + DEPTH - 1) % DEPTH;
        m_cnt--;
      end
    end else if (push_i) begin
      m_top = (m_top + 1) % DEPTH;
      for (int k = 0; k < 2; k++) m_mem[k][m_top] = pc_i + step_of(k);
      if (m_cnt < DEPTH) m_cnt++;
    end
  endtask

  task automatic step(string tag, bit pu, bit po, logic [AW-1:0] pc,
                      bit rs = 1'b0, int ridx = 0, logic [AW-1:0] rtgt = '0, bit ud = 1'b0);
    @(negedge clk);
    push_i = pu; pop_i = po; pc_i = pc; restore_i = rs;
    restore_idx_i = IW'(ridx); restore_tgt_i = rtgt; undo_push_i = ud;
    #1 compare(tag);
    @(posedge clk);
    #1 model_update();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 2; k++) for (int i = 0; i < DEPTH; i++) m_mem[k][i] = '0;
    m_top = 0; m_cnt = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1'b1;

    step("R1", 0, 0, 32'h0);
    // R2: calls push past the delay slot
    step("R2", 1, 0, 32'h1000);
    step("R2", 1, 0, 32'h2000);
    step("R2", 0, 0, 32'h0);
    // R3: returns pop newest first
    step("R3", 0, 1, 32'h2100);
    step("R3", 0, 1, 32'h1100);
    // R4: return on empty stack
    step("R4", 0, 1, 32'h3000);
    step("R4", 0, 0, 32'h0);
    // R5: checkpoint of a return
    step("R5", 1, 0, 32'h4000);
    step("R5", 1, 0, 32'h5000);
    step("R5", 0, 1, 32'h5100);
    // R6: wrong-path push clobbers, restore repairs
    step("R6", 1, 0, 32'h6000);
    step("R6", 0, 0, 32'h0, 1'b1, 2, 32'h5008);
    step("R6", 0, 0, 32'h0);
    // R7: undo of a speculative call
    step("R7", 1, 0, 32'h7000);
    step("R7", 0, 0, 32'h0, 1'b0, 0, '0, 1'b1);
    step("R7", 0, 0, 32'h0);
    // R8: overflow wraps over the oldest entry
    for (int i = 1; i <= DEPTH + 3; i++) step("R8", 1, 0, AW'(i * 32'h100));
    for (int i = 0; i < DEPTH; i++) step("R8", 0, 1, 32'h9000);
    step("R8", 0, 1, 32'h9000);
    step("R8", 0, 0, 32'h0);
    // R9: restore beats a call
    step("R9", 1, 0, 32'hA000, 1'b1, 5, 32'hBEEF0000);
    step("R9", 0, 0, 32'h0);
    step("R9", 1, 1, 32'hA100, 1'b1, 9, 32'hCAFE0000, 1'b1);
    step("R9", 0, 0, 32'h0);
    // R10: call ignored during a return
    step("R10", 1, 1, 32'hB000);
    step("R10", 0, 0, 32'h0);
    step("R10", 0, 1, 32'hB100);
    step("R10", 1, 1, 32'hB200);
    step("R10", 0, 0, 32'h0);
    // R11: undo on empty
    step("R11", 0, 0, 32'h0, 1'b0, 0, '0, 1'b1);
    step("R11", 0, 0, 32'h0);
    // R12: undo beats return and call
    step("R12", 1, 0, 32'hC000);
    step("R12", 1, 0, 32'hD000);
    step("R12", 0, 1, 32'hD100, 1'b0, 0, '0, 1'b1);
    step("R12", 1, 0, 32'hE000, 1'b0, 0, '0, 1'b1);
    step("R12", 0, 0, 32'h0);
    step("R12", 0, 1, 32'hF000);
    // R13: delay-slot-free variant checked in every step above
    step("R13", 1, 0, 32'h12340);
    step("R13", 0, 1, 32'h0);
    step("R13", 0, 1, 32'h55550);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule